// File: doc/BRIEF.md
# Chained Serial Line Receiver with Column Window Selection

This block sits at the input of one display controller in a chain of identical controllers. Three serial lanes carry one display line per frame, one lane per primary colour. The lanes are sampled on the source-synchronous clock, which is also the block clock, one bit per lane per cycle. The block hunts for a fixed 32-bit pseudo-random pattern that opens each frame and then decodes a 16-bit line number and an 8-bit position code. The position code tells the controller which slice of the line is its own. Pixels in that slice go out through a local write port, addressed by line and column. All other pixels only pass through.

Every bit on the three lanes is also retransmitted toward the next controller after a fixed delay. Only the position code is changed: it is raised by one. No address switches are needed, because a controller learns its place from the upstream controllers and the first one receives code 0. The decoded line number is compared with the previous accepted line so that a dropped frame is reported.

Top module: `line_frame_rx`

## Requirements
- R1: A frame is accepted only when the last 32 bits on all three lanes equal `SYNC_WORD` (the first bit received is the MSB) while the block is hunting. If any lane differs in any bit, nothing is decoded: no write, no line check, and the forwarded stream is an unmodified delayed copy.
- R2: After the sync pattern, each lane carries the 16-bit line number, the 8-bit position code and then `LINE_PIX` pixels of 8 bits. All fields are sent MSB first. Header fields are decoded from the red lane (`rx_bits[2]`). Pixel bits are taken from red `rx_bits[2]`, green `rx_bits[1]` and blue `rx_bits[0]`. `wr_data` packs them as red [23:16], green [15:8] and blue [7:0].
- R3: For the pixel with index p, counted from 0, `wr_en` is high for exactly one cycle when p is in the range `WIN`*code to `WIN`*(code+1)-1. That cycle is the one after its last bit is sampled.
- R4: Pixels outside the window produce no write. A code whose window lies beyond the line produces no write at all.
- R5: `wr_addr` equals {line number[`ROW_W`-1:0], p mod `WIN`}. `WIN` is a power of two.
- R6: `fwd_bits` equals `rx_bits` delayed by 7 cycles, bit for bit. The exception is the 8 position-code bits of an accepted frame, which carry (code+1) mod 256 in the same bit slots.
- R7: `line_lost` is high for exactly one cycle, the one after the last line-number bit is sampled, when the new line is not the previously accepted line plus 1 (mod 2^16).
- R8: Line 0 never raises `line_lost`, and neither does the first accepted frame after reset.
- R9: During and right after reset, `wr_en`, `line_lost` and `fwd_bits` are 0.
- R10: After the last pixel bit, the block hunts again at once, so a sync pattern that starts in the very next cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source-synchronous bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bits | input | 3 | Incoming lane bits: [2] red, [1] green, [0] blue |
| fwd_bits | output | 3 | Retransmitted lane bits toward the next controller |
| wr_en | output | 1 | Local pixel write strobe |
| wr_addr | output | ROW_W+log2(WIN) | Local pixel address {line, column} |
| wr_data | output | 24 | Pixel {red, green, blue} |
| line_lost | output | 1 | One-cycle pulse on a line-number gap |

## Verification
The bench builds the block with `LINE_PIX` = 12, `WIN` = 4 and `ROW_W` = 3. A full line then holds three windows in about 150 bit cycles, so codes 0, 1 and 2 each own a slice, code 3 falls past the line end, and code 255 exercises the wrap of the forwarded increment. A short line also allows a sequence of ten frames in one short run. That sequence covers back-to-back frames, a corrupted sync on one lane, a line gap, a repeated line, and a restart at line 0. Line addresses wrap at 8, so the low-bit truncation of the line number shows up in `wr_addr`.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    localparam int LANES  = 3;
    localparam int SYNC_W = 32;
    localparam int LNUM_W = 16;
    localparam int ID_W   = 8;
    localparam int PIX_W  = 8;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_LNUM,
        ST_ID,
        ST_PIX
    } rx_state_e;

    typedef struct packed {
        logic [PIX_W-1:0] r;
        logic [PIX_W-1:0] g;
        logic [PIX_W-1:0] b;
    } rgb_t;

    // A gap is reported only when a previous line exists and the new line is
    // neither a field restart (0) nor the successor of the previous one.
    function automatic logic lnum_gap(input logic              have_prev,
                                      input logic [LNUM_W-1:0] prev,
                                      input logic [LNUM_W-1:0] cur);
        return have_prev && (cur != '0) && (cur != prev + LNUM_W'(1));
    endfunction

endpackage

// File: rtl/lfr_sync_hunt.sv
module lfr_sync_hunt
    import lfr_pkg::*;
#(
    parameter logic [SYNC_W-1:0] PATTERN = 32'hB38F_1D65
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lane_bit,
    output logic             hit
);

    logic [LANES-1:0] lane_hit;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SYNC_W-2:0] hist;

        always_ff @(posedge clk) begin
            if (rst) hist <= '0;
            else     hist <= {hist[SYNC_W-3:0], lane_bit[l]};
        end

        assign lane_hit[l] = ({hist, lane_bit[l]} == PATTERN);
    end

    assign hit = &lane_hit;

endmodule

// File: rtl/lfr_fwd_lane.sv
module lfr_fwd_lane
    import lfr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bump,
    output logic bit_out
);

    logic [ID_W-1:0] dl;
    logic [ID_W-1:0] dl_next;

    assign dl_next = {dl[ID_W-2:0], bit_in};

    // When the last code bit enters, the whole code sits in the delay line
    // with its MSB at the output end; it is replaced by its successor.
    always_ff @(posedge clk) begin
        if (rst)       dl <= '0;
        else if (bump) dl <= dl_next + ID_W'(1);
        else           dl <= dl_next;
    end

    assign bit_out = dl[ID_W-1];

endmodule

// File: rtl/lfr_pix_deser.sv
module lfr_pix_deser
    import lfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lane_bit,
    output rgb_t             word
);

    logic [PIX_W-1:0] lane_word [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PIX_W-2:0] sh;

        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[PIX_W-3:0], lane_bit[l]};
        end

        assign lane_word[l] = {sh, lane_bit[l]};
    end

    assign word.r = lane_word[2];
    assign word.g = lane_word[1];
    assign word.b = lane_word[0];

endmodule

// File: rtl/line_frame_rx.sv
module line_frame_rx
    import lfr_pkg::*;
#(
    parameter logic [31:0] SYNC_WORD = 32'hB38F_1D65,
    parameter int          LINE_PIX  = 384,
    parameter int          WIN       = 128,
    parameter int          ROW_W     = 7,
    localparam int         COL_W     = $clog2(WIN),
    localparam int         ADDR_W    = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        rx_bits,
    output logic [2:0]        fwd_bits,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [23:0]       wr_data,
    output logic              line_lost
);

    localparam int NSEG  = LINE_PIX / WIN;
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam int CNT_W = $clog2(LNUM_W);

    localparam logic [CNT_W-1:0] LNUM_LAST = CNT_W'(LNUM_W - 1);
    localparam logic [CNT_W-1:0] ID_LAST   = CNT_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] PIX_LAST  = CNT_W'(PIX_W - 1);
    localparam logic [COL_W-1:0] COL_LAST  = COL_W'(WIN - 1);
    localparam logic [SEG_W-1:0] SEG_LAST  = SEG_W'(NSEG - 1);

    rx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [COL_W-1:0]   col;
    logic [SEG_W-1:0]   seg;
    logic [LNUM_W-2:0]  hdr_sh;
    logic [LNUM_W-1:0]  hdr_word;
    logic [LNUM_W-1:0]  line_q;
    logic               have_line;
    logic [ID_W-1:0]    id_q;
    logic               sync_hit;
    logic               bump;
    logic               in_win;
    rgb_t               pix_word;

    // ---------------- sub-blocks ----------------
    lfr_sync_hunt #(.PATTERN(SYNC_WORD)) i_hunt (
        .clk      (clk),
        .rst      (rst),
        .lane_bit (rx_bits),
        .hit      (sync_hit)
    );

    lfr_pix_deser i_deser (
        .clk      (clk),
        .rst      (rst),
        .lane_bit (rx_bits),
        .word     (pix_word)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        lfr_fwd_lane i_lane (
            .clk     (clk),
            .rst     (rst),
            .bit_in  (rx_bits[l]),
            .bump    (bump),
            .bit_out (fwd_bits[l])
        );
    end

    // ---------------- header shift on the red lane ----------------
    always_ff @(posedge clk) begin
        if (rst) hdr_sh <= '0;
        else     hdr_sh <= {hdr_sh[LNUM_W-3:0], rx_bits[2]};
    end

    assign hdr_word = {hdr_sh, rx_bits[2]};
    assign bump     = (state == ST_ID) && (cnt == ID_LAST);
    assign in_win   = (32'(seg) == 32'(id_q));

    // ---------------- frame sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            cnt       <= '0;
            col       <= '0;
            seg       <= '0;
            line_q    <= '0;
            have_line <= 1'b0;
            id_q      <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            line_lost <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            line_lost <= 1'b0;
            unique case (state)
                ST_HUNT: begin
                    cnt <= '0;
                    if (sync_hit) state <= ST_LNUM;
                end
                ST_LNUM: begin
                    if (cnt == LNUM_LAST) begin
                        line_lost <= lnum_gap(have_line, line_q, hdr_word);
                        line_q    <= hdr_word;
                        have_line <= 1'b1;
                        cnt       <= '0;
                        state     <= ST_ID;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_ID: begin
                    if (cnt == ID_LAST) begin
                        id_q  <= hdr_word[ID_W-1:0];
                        cnt   <= '0;
                        col   <= '0;
                        seg   <= '0;
                        state <= ST_PIX;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_PIX: begin
                    if (cnt == PIX_LAST) begin
                        cnt     <= '0;
                        wr_en   <= in_win;
                        wr_data <= pix_word;
                        wr_addr <= {line_q[ROW_W-1:0], col};
                        if (col == COL_LAST) begin
                            col <= '0;
                            if (seg == SEG_LAST) state <= ST_HUNT;
                            else                 seg   <= seg + SEG_W'(1);
                        end else begin
                            col <= col + COL_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // ---------------- assertions ----------------
    p_lost_single_r7: assert property (@(posedge clk) disable iff (rst)
        line_lost |=> !line_lost);

    p_lost_from_header_r7: assert property (@(posedge clk) disable iff (rst)
        line_lost |-> $past(state) == ST_LNUM);

    p_write_from_pixels_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(state) == ST_PIX);

    p_write_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    p_hunt_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT && $past(state) == ST_HUNT) |-> !wr_en);

    p_id_after_line_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_ID) |-> $past(state) == ST_LNUM);

endmodule

// File: tb/test_line_frame_rx.sv
module test_line_frame_rx;

    localparam logic [31:0] SYNC = 32'hB38F_1D65;
    localparam int LPIX = 12;
    localparam int WN   = 4;
    localparam int RW   = 3;
    localparam int AW   = RW + 2;
    localparam int N    = 2400;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    rx_bits = '0;
    logic [2:0]    fwd_bits;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [23:0]   wr_data;
    logic          line_lost;

    always #4 clk = ~clk;

    line_frame_rx #(.SYNC_WORD(SYNC), .LINE_PIX(LPIX), .WIN(WN), .ROW_W(RW))
        i_line_frame_rx (
            .clk(clk), .rst(rst), .rx_bits(rx_bits), .fwd_bits(fwd_bits),
            .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
            .line_lost(line_lost));

    logic [2:0]    in_v    [N];
    bit            ov_en   [N];
    logic [2:0]    ov_bits [N];
    bit            ex_wr   [N];
    logic [AW-1:0] ex_addr [N];
    logic [23:0]   ex_data [N];
    bit            ex_lost [N];
    string         wr_tag  [N];
    string         lost_tag[N];

    int checks = 0;
    int errors = 0;
    int pos    = 0;
    int fno    = 0;
    bit have_prev = 0;
    int prev_line = 0;
    bit done = 0;

    function automatic int pval(int f, int lane, int p);
        return (f * 29 + p * 37 + lane * 71 + 5) & 255;
    endfunction

    task automatic put3(int t, bit b);
        in_v[t] = {b, b, b};
    endtask

    task automatic add_frame(int line, int id, int bad_lane, int gap, string tg);
        int s = pos;
        for (int k = 0; k < 32; k++) begin
            put3(s + k, SYNC[31-k]);
            if (bad_lane >= 0 && k == 17) in_v[s+k][bad_lane] = ~SYNC[31-k];
        end
        for (int j = 0; j < 16; j++) put3(s + 32 + j, line[15-j]);
        for (int j = 0; j < 8; j++)  put3(s + 48 + j, id[7-j]);
        for (int p = 0; p < LPIX; p++)
            for (int b = 0; b < 8; b++)
                for (int l = 0; l < 3; l++)
                    in_v[s+56+8*p+b][l] = pval(fno, l, p) >> (7 - b);
        for (int p = 0; p < LPIX; p++) wr_tag[s+63+8*p] = (bad_lane >= 0) ? "R1" : tg;
        if (bad_lane < 0) begin
            int nid = (id + 1) & 255;
            if (have_prev && line != 0 && line != ((prev_line + 1) & 16'hFFFF))
                ex_lost[s+47] = 1;
            lost_tag[s+47] = (!have_prev || line == 0) ? "R8" : "R7";
            have_prev = 1;
            prev_line = line;
            for (int j = 0; j < 8; j++) begin
                ov_en[s+55+j]   = 1;
                ov_bits[s+55+j] = {3{nid[7-j]}};
            end
            for (int p = 0; p < LPIX; p++) begin
                if (p / WN == id) begin
                    int t = s + 63 + 8 * p;
                    ex_wr[t]   = 1;
                    ex_addr[t] = AW'((line % (1 << RW)) * WN + p % WN);
                    ex_data[t] = {8'(pval(fno, 2, p)), 8'(pval(fno, 1, p)), 8'(pval(fno, 0, p))};
                end
            end
        end
        pos = s + 56 + 8 * LPIX + gap;
        fno++;
    endtask

    task automatic check_cycle(int t);
        logic [2:0] ef;
        ef = (t >= 7) ? in_v[t-7] : 3'b000;
        if (ov_en[t]) ef = ov_bits[t];
        checks++;
        if (fwd_bits !== ef) begin
            errors++;
            $display("FAIL R6 t=%0d fwd_bits actual=%b expected=%b", t, fwd_bits, ef);
        end
        checks++;
        if (wr_en !== ex_wr[t]) begin
            errors++;
            $display("FAIL %s t=%0d wr_en actual=%b expected=%b", wr_tag[t], t, wr_en, ex_wr[t]);
        end
        if (ex_wr[t] && wr_en) begin
            checks++;
            if (wr_addr !== ex_addr[t]) begin
                errors++;
                $display("FAIL R5 t=%0d wr_addr actual=%0d expected=%0d", t, wr_addr, ex_addr[t]);
            end
            checks++;
            if (wr_data !== ex_data[t]) begin
                errors++;
                $display("FAIL R2 t=%0d wr_data actual=%h expected=%h", t, wr_data, ex_data[t]);
            end
        end
        checks++;
        if (line_lost !== ex_lost[t]) begin
            errors++;
            $display("FAIL %s t=%0d line_lost actual=%b expected=%b", lost_tag[t], t, line_lost, ex_lost[t]);
        end
    endtask

    initial begin
        for (int t = 0; t < N; t++) begin
            in_v[t] = '0; ov_en[t] = 0; ov_bits[t] = '0; ex_wr[t] = 0;
            ex_addr[t] = '0; ex_data[t] = '0; ex_lost[t] = 0;
            wr_tag[t] = "R3"; lost_tag[t] = "R7";
        end
        add_frame(0,   0,   -1, 40, "R3");  // first frame, line 0 (R8)
        add_frame(1,   1,   -1, 40, "R3");
        add_frame(2,   2,   -1, 0,  "R3");  // next frame back to back (R10)
        add_frame(3,   3,   -1, 40, "R10"); // window past line end (R4)
        add_frame(7,   0,   -1, 40, "R3");  // gap 3 -> 7 (R7)
        add_frame(8,   1,   1,  40, "R1");  // corrupted sync on green lane
        add_frame(8,   255, -1, 40, "R4");  // code wraps to 0 downstream (R6)
        add_frame(0,   1,   -1, 40, "R3");  // restart at line 0 (R8)
        add_frame(1,   2,   -1, 40, "R3");
        add_frame(1,   0,   -1, 40, "R3");  // repeated line (R7)

        // R9: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (wr_en !== 1'b0 || line_lost !== 1'b0 || fwd_bits !== 3'b000) begin
            errors++;
            $display("FAIL R9 reset outputs actual=%b%b%b expected=00000", wr_en, line_lost, fwd_bits);
        end
        rst = 1'b0;
        rx_bits = in_v[0];
        for (int t = 1; t <= pos; t++) begin
            @(negedge clk);
            check_cycle(t - 1);
            rx_bits = (t < N) ? in_v[t] : 3'b000;
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule